// File: doc/BRIEF.md
# Pipelined Table-Lookup Bit Counter

This block counts how many bits are set in a 24-bit word. It returns a 5-bit binary count from 0 to 24 and accepts a new word on every clock. The count is formed by two levels of registered lookup tables that behave like synchronous-read ROMs. This lets the block map onto on-chip block memory instead of a carry chain.

The first level has one 2048-entry table that is read through two ports. One port is addressed by input bits [10:0] and the other by bits [21:11]. Each port returns a 4-bit count of ones. The second level is a 1024-entry table with 4-bit entries. Its address is {count of bits [10:0], count of bits [21:11], bit 23, bit 22}, and its entry is the sum of those four terms shifted right by one. That entry supplies the upper four bits of the result. A single register beside the second table supplies the result LSB. It holds the XOR of the two partial-count LSBs and the XOR of bits 23 and 22, which is their sum bit with the carry dropped.

A word is captured on the clock edge where `in_valid_i` is high. Its count appears after the following edge together with `out_valid_o`.

Top module: `popc24_pipe`

## Requirements
- R1: When `out_valid_o` is high, `out_count_o` equals the number of set bits in the 24-bit word that produced it. The count is an unsigned binary value in 5 bits.
- R2: A word sampled on a rising edge with `in_valid_i` high shows its count with `out_valid_o` high after the next rising edge. That is a latency of two edges, so the result is visible in the cycle after the second edge.
- R3: Words presented with `in_valid_i` high on consecutive cycles each produce a correct result on consecutive cycles, with no gaps.
- R4: `out_valid_o` is low in any cycle whose word two edges earlier was not valid. Data presented with `in_valid_i` low never causes a valid result.
- R5: When `rst_i` is high on a rising edge, every valid stage is cleared. `out_valid_o` is low in the cycle that follows. Words that were in flight at that edge, or presented during reset, produce no valid result.
- R6: An all-zeros word gives a count of 0, and an all-ones word gives a count of 24.
- R7: Bit 0 of `out_count_o` equals the XOR of all 24 input bits of the word that produced it.
- R8: A word with exactly one set bit gives a count of 1 for every position 0 to 23. A word with exactly one clear bit gives a count of 23 for every position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all registers use its rising edge |
| rst_i | input | 1 | Synchronous active-high reset of the valid stages |
| in_valid_i | input | 1 | High when `in_data_i` holds a word to count |
| in_data_i | input | 24 | Word whose set bits are counted |
| out_valid_o | output | 1 | High when `out_count_o` holds a result |
| out_count_o | output | 5 | Number of set bits, 0 to 24 |

## Verification
The assertions that compare the result with the word two edges earlier rely on `in_data_i` being a known value at every sampled edge, including edges where `in_valid_i` is low. The bench therefore drives zero on the data input from time zero and always drives a defined value, including during idle gaps and reset. The table-level checks also assume `rst_i` is high at the first edges, so that no `$past` value before the first clock is used. The bench holds reset over the first cycles and changes every input on the falling edge.

// File: rtl/popc_pkg.sv
package popc_pkg;

    // Default geometry of the counter: word width and width of one table slice.
    localparam int unsigned POPC_WORD_W  = 24;
    localparam int unsigned POPC_SLICE_W = 11;

    // Number of result bits needed to hold a count of 0..n.
    function automatic int unsigned count_bits(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/popc_lut_pair.sv
// First level: one counting table read through two synchronous ports.
module popc_lut_pair #(
    parameter int unsigned ADDR_W = popc_pkg::POPC_SLICE_W,
    parameter int unsigned CNT_W  = popc_pkg::count_bits(ADDR_W)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_a_i,
    input  logic [ADDR_W-1:0] addr_b_i,
    output logic [CNT_W-1:0]  cnt_a_o,
    output logic [CNT_W-1:0]  cnt_b_o
);
    localparam int unsigned DEPTH = 2 ** ADDR_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt_a;
        logic [CNT_W-1:0] cnt_b;
    } rd_t;

    logic [CNT_W-1:0] table_w [DEPTH];

    // Table contents: each entry holds the number of ones in its own address.
    for (genvar i = 0; i < DEPTH; i++) begin : g_fill
        assign table_w[i] = CNT_W'($countones(i));
    end

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d.cnt_a = table_w[addr_a_i];
        rd_d.cnt_b = table_w[addr_b_i];
    end

    always_ff @(posedge clk_i) begin
        rd_q <= rd_d;
    end

    assign cnt_a_o = rd_q.cnt_a;
    assign cnt_b_o = rd_q.cnt_b;

    // R1
    slice_a_count_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_a_o == CNT_W'($countones($past(addr_a_i))));

    // R1
    slice_b_count_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_b_o == CNT_W'($countones($past(addr_b_i))));

endmodule

// File: rtl/popc_merge_lut.sv
// Second level: merges two partial counts and the raw leftover bits into the
// upper result bits, with a synchronous read.
module popc_merge_lut #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned RAW_W = 2,
    parameter int unsigned HI_W  = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CNT_W-1:0] cnt_a_i,
    input  logic [CNT_W-1:0] cnt_b_i,
    input  logic [RAW_W-1:0] raw_i,
    output logic [HI_W-1:0]  upper_o
);
    localparam int unsigned ADDR_W = 2 * CNT_W + RAW_W;
    localparam int unsigned DEPTH  = 2 ** ADDR_W;

    logic [HI_W-1:0] table_w [DEPTH];

    // Entry for address {a, b, raw} is (a + b + ones(raw)) >> 1.
    for (genvar i = 0; i < DEPTH; i++) begin : g_fill
        localparam int unsigned PART_A = i / (2 ** (CNT_W + RAW_W));
        localparam int unsigned PART_B = (i / (2 ** RAW_W)) % (2 ** CNT_W);
        localparam int unsigned PART_X = $countones(i % (2 ** RAW_W));
        assign table_w[i] = HI_W'((PART_A + PART_B + PART_X) >> 1);
    end

    logic [ADDR_W-1:0] addr_w;
    logic [HI_W-1:0]   upper_d, upper_q;

    assign addr_w = {cnt_a_i, cnt_b_i, raw_i};

    always_comb begin
        upper_d = table_w[addr_w];
    end

    always_ff @(posedge clk_i) begin
        upper_q <= upper_d;
    end

    assign upper_o = upper_q;

    // R1
    merge_sum_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        upper_o == HI_W'((int'($past(cnt_a_i)) + int'($past(cnt_b_i))
                          + $countones($past(raw_i))) >> 1));

endmodule

// File: rtl/popc24_pipe.sv
// Top: two-level registered table counter with a parallel parity path.
module popc24_pipe #(
    parameter int unsigned WORD_W  = popc_pkg::POPC_WORD_W,
    parameter int unsigned SLICE_W = popc_pkg::POPC_SLICE_W
) (
    input  logic                                     clk_i,
    input  logic                                     rst_i,
    input  logic                                     in_valid_i,
    input  logic [WORD_W-1:0]                        in_data_i,
    output logic                                     out_valid_o,
    output logic [popc_pkg::count_bits(WORD_W)-1:0]  out_count_o
);
    localparam int unsigned RAW_W = WORD_W - 2 * SLICE_W;
    localparam int unsigned CNT_W = popc_pkg::count_bits(SLICE_W);
    localparam int unsigned OUT_W = popc_pkg::count_bits(WORD_W);
    localparam int unsigned HI_W  = OUT_W - 1;

    typedef struct packed {
        logic             vld1;
        logic             vld2;
        logic [RAW_W-1:0] raw;
        logic             lsb;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [CNT_W-1:0] cnt_a_w, cnt_b_w;
    logic [HI_W-1:0]  upper_w;

    popc_lut_pair #(
        .ADDR_W (SLICE_W),
        .CNT_W  (CNT_W)
    ) u_level1 (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .addr_a_i (in_data_i[SLICE_W-1:0]),
        .addr_b_i (in_data_i[2*SLICE_W-1:SLICE_W]),
        .cnt_a_o  (cnt_a_w),
        .cnt_b_o  (cnt_b_w)
    );

    popc_merge_lut #(
        .CNT_W (CNT_W),
        .RAW_W (RAW_W),
        .HI_W  (HI_W)
    ) u_level2 (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .cnt_a_i (cnt_a_w),
        .cnt_b_i (cnt_b_w),
        .raw_i   (pipe_q.raw),
        .upper_o (upper_w)
    );

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.raw = in_data_i[WORD_W-1 -: RAW_W];
        // Parity path: the sum bit of the leftovers, with no carry, joins the slice LSBs.
        pipe_d.lsb = cnt_a_w[0] ^ cnt_b_w[0] ^ (^pipe_q.raw);
        if (rst_i) begin
            pipe_d.vld1 = 1'b0;
            pipe_d.vld2 = 1'b0;
        end else begin
            pipe_d.vld1 = in_valid_i;
            pipe_d.vld2 = pipe_q.vld1;
        end
    end

    always_ff @(posedge clk_i) begin
        pipe_q <= pipe_d;
    end

    assign out_valid_o = pipe_q.vld2;
    assign out_count_o = {upper_w, pipe_q.lsb};

    // R2
    latency_valid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        out_valid_o |-> $past(in_valid_i, 2));

    // R4
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(in_valid_i, 2) |-> !out_valid_o);

    // R5
    reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !out_valid_o);

    // R1
    full_count_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        out_valid_o |-> out_count_o == OUT_W'($countones($past(in_data_i, 2))));

    // R7
    parity_lsb_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        out_valid_o |-> out_count_o[0] == ^$past(in_data_i, 2));

endmodule

// File: tb/tb_popc24_pipe.sv
module tb_popc24_pipe;

    localparam int unsigned WORD_W = 24;
    localparam int unsigned OUT_W  = 5;
    localparam int unsigned WATCHDOG_CYCLES = 100000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [WORD_W-1:0] in_data = '0;
    logic              out_valid;
    logic [OUT_W-1:0]  out_count;

    int n_tests = 0;
    int n_fail  = 0;

    // Words driven one and two steps earlier, as the bench expects them.
    logic              h1_v = 1'b0, h2_v = 1'b0;
    logic [WORD_W-1:0] h1_d = '0,   h2_d = '0;
    logic [31:0]       rng  = 32'h1234_5678;

    always #4 clk = ~clk;

    popc24_pipe dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .in_valid_i  (in_valid),
        .in_data_i   (in_data),
        .out_valid_o (out_valid),
        .out_count_o (out_count)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // One falling-edge step: check the result of the word from two steps ago,
    // then drive the next word.
    task automatic step(input logic r, input logic v, input logic [WORD_W-1:0] d,
                        input string tag);
        logic [OUT_W-1:0] exp_cnt;
        @(negedge clk);
        n_tests++;
        if (out_valid !== h2_v) begin
            n_fail++;
            $display("FAIL %s valid: got %0b expected %0b", tag, out_valid, h2_v);
        end
        if (h2_v) begin
            exp_cnt = OUT_W'($countones(h2_d));
            n_tests++;
            if (out_count !== exp_cnt) begin
                n_fail++;
                $display("FAIL %s/R1 count for %h: got %0d expected %0d",
                         tag, h2_d, out_count, exp_cnt);
            end
            n_tests++;
            if (out_count[0] !== (^h2_d)) begin
                n_fail++;
                $display("FAIL %s/R7 lsb for %h: got %0b expected %0b",
                         tag, h2_d, out_count[0], ^h2_d);
            end
        end
        // A reset edge drops everything in flight and the word being presented.
        if (r) h1_v = 1'b0;
        h2_v = h1_v;
        h2_d = h1_d;
        h1_v = v && !r;
        h1_d = d;
        rst      = r;
        in_valid = v;
        in_data  = d;
    endtask

    task automatic flush(input string tag);
        step(1'b0, 1'b0, '0, tag);
        step(1'b0, 1'b0, '0, tag);
    endtask

    // R5: outputs idle while reset is held, even with valid words presented.
    task automatic t_reset_state();
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 24'hA5A5A5, "R5");
        flush("R5");
    endtask

    // R6: the two extreme words.
    task automatic t_extremes();
        step(1'b0, 1'b1, 24'h000000, "R6");
        step(1'b0, 1'b1, 24'hFFFFFF, "R6");
        flush("R6");
    endtask

    // R2: an isolated word shows its result exactly two edges later.
    task automatic t_latency();
        step(1'b0, 1'b1, 24'hC00001, "R2");
        step(1'b0, 1'b0, 24'hFFFFFF, "R2");
        step(1'b0, 1'b0, 24'hFFFFFF, "R2");
        step(1'b0, 1'b0, '0, "R2");
    endtask

    // R8: walking one and walking zero across all 24 positions.
    task automatic t_walk();
        for (int i = 0; i < WORD_W; i++) step(1'b0, 1'b1, WORD_W'(1) << i, "R8");
        for (int i = 0; i < WORD_W; i++) step(1'b0, 1'b1, ~(WORD_W'(1) << i), "R8");
        flush("R8");
    endtask

    // R3: back-to-back random words.
    task automatic t_stream();
        for (int i = 0; i < 400; i++) begin
            rng = next_rand(rng);
            step(1'b0, 1'b1, rng[WORD_W-1:0], "R3");
        end
        flush("R3");
    endtask

    // R4: valid gaps, with non-zero data presented while valid is low.
    task automatic t_gaps();
        for (int i = 0; i < 40; i++) begin
            rng = next_rand(rng);
            step(1'b0, rng[31], rng[WORD_W-1:0], "R4");
        end
        flush("R4");
    endtask

    // R5: reset in the middle of a stream drops the words in flight.
    task automatic t_reset_mid();
        step(1'b0, 1'b1, 24'h0F0F0F, "R5");
        step(1'b0, 1'b1, 24'h333333, "R5");
        step(1'b1, 1'b1, 24'h777777, "R5");
        step(1'b0, 1'b1, 24'h800000, "R5");
        step(1'b0, 1'b1, 24'hFFFFFE, "R5");
        flush("R5");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset_state();
        t_extremes();
        t_latency();
        t_walk();
        t_stream();
        t_gaps();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule